// File: doc/BRIEF.md
# Dual-Compare 8-bit PWM Timer

The block is an up-counter advanced by a count-clock enable. Two compare values shape a PWM waveform. The period value sets the length of the cycle. When the counter reaches it, the counter returns to zero, the output goes to its active level and a one-cycle interrupt pulse fires. The duty value marks the point where the output drops back to its inactive level. At the duty point the counter keeps counting and no interrupt is raised.

A run-enable input starts and stops the timer. After enable, the first qualified tick is swallowed, so the counter stays at zero for one extra count period. A polarity input selects whether the active level is high or low. Dropping run-enable stops everything at once. The output goes inactive and the interrupt goes low in the same cycle, and the counter returns to zero on the next clock.

The compare values must satisfy duty < period. The duty value may be zero and the period value may be as high as FFh. Outside that range the behaviour is not defined.

Top module: `pwm8_dual_cmp`

## Requirements
- R1: After the active-low asynchronous reset, count_o is 00h, irq_o is 0 and pwm_o sits at its inactive level (pwm_o == inv_i).
- R2: While running and past the masked tick, count_o rises by one on each clock where tick_i is 1 and holds on clocks where tick_i is 0.
- R3: The first tick_i after run_i goes to 1 (or after reset with run_i at 1) is masked, and count_o stays at 00h through it; the next tick moves it to 01h.
- R4: On a tick where count_o equals period_i, the next clock shows count_o at 00h, the output at its active level and irq_o at 1.
- R5: On a tick where count_o equals duty_i (and not period_i), the output returns to its inactive level, count_o still increments and irq_o stays 0.
- R6: irq_o is high for exactly one clock per period match and is never high on two consecutive clocks.
- R7: With inv_i = 0 the active level is 1 and the inactive level is 0; with inv_i = 1 the active level is 0 and the inactive level is 1.
- R8: While run_i is 0, pwm_o is at its inactive level and irq_o is 0 in that same cycle. count_o is 00h from the next clock, and a later enable masks its first tick again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one qualified tick per high cycle |
| run_i | input | 1 | Run enable |
| inv_i | input | 1 | Polarity select: 0 active high, 1 active low |
| period_i | input | 8 | Period compare value (N) |
| duty_i | input | 8 | Duty compare value (M), M < N |
| count_o | output | 8 | Current counter value |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | One-cycle period-match pulse |

## Verification
The hardest case to reach is the handover between the masked first tick and real counting when run_i is dropped and raised again in the middle of a period. A stale counter or a stale phase state would then show up only as a one-tick shift in the next waveform. To reach it, the stimulus stops the timer while the output is active, checks that pwm_o and irq_o drop in the same cycle, and re-enables with ticks arriving both back-to-back and sparsely. A behavioural reference model checks every clock against the design, so any misplaced tick is caught. Duty value zero and period value FFh are run as the extreme corners.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  localparam int unsigned N_CMP  = 2;
  localparam int unsigned CMP_PER = 0;
  localparam int unsigned CMP_DTY = 1;
endpackage

// File: rtl/pwm8_seq.sv
module pwm8_seq
  import pwm8_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic cnt_en_o,
  output logic clr_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (run_i) ph_d = tick_i ? PH_RUN : PH_ARM;
      PH_ARM:  if (!run_i) ph_d = PH_IDLE; else if (tick_i) ph_d = PH_RUN;
      PH_RUN:  if (!run_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
    if (!run_i) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // first qualified tick after enable is swallowed by IDLE/ARM
  assign cnt_en_o = run_i & tick_i & (ph_q == PH_RUN);
  assign clr_o    = ~run_i;
endmodule

// File: rtl/pwm8_cmp.sv
module pwm8_cmp
  import pwm8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  output logic         hit_per_o,
  output logic         hit_dty_o
);
  logic [W-1:0] ref_val [N_CMP];
  logic [N_CMP-1:0] hit;

  assign ref_val[CMP_PER] = period_i;
  assign ref_val[CMP_DTY] = duty_i;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign hit[g] = (cnt_i == ref_val[g]);
  end

  assign hit_per_o = hit[CMP_PER];
  assign hit_dty_o = hit[CMP_DTY];
endmodule

// File: rtl/pwm8_cnt.sv
module pwm8_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         wrap_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= wrap_i ? '0 : cnt_o + ONE;
  end
endmodule

// File: rtl/pwm8_lvl.sv
module pwm8_lvl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic hit_per_i,
  input  logic hit_dty_i,
  output logic act_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      irq_o <= 1'b0;
    end else if (clr_i) begin
      act_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= en_i & hit_per_i;
      if (en_i) begin
        // period match wins: counter is cleared, so duty cannot also act
        if (hit_per_i)      act_o <= 1'b1;
        else if (hit_dty_i) act_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm8_dual_cmp.sv
module pwm8_dual_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         inv_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  output logic [W-1:0] count_o,
  output logic         pwm_o,
  output logic         irq_o
);
  logic cnt_en, clr, hit_per, hit_dty, act_q, irq_q;

  pwm8_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .tick_i   (tick_i),
    .cnt_en_o (cnt_en),
    .clr_o    (clr)
  );

  pwm8_cmp #(.W(W)) u_cmp (
    .cnt_i     (count_o),
    .period_i  (period_i),
    .duty_i    (duty_i),
    .hit_per_o (hit_per),
    .hit_dty_o (hit_dty)
  );

  pwm8_cnt #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (cnt_en),
    .wrap_i (hit_per),
    .cnt_o  (count_o)
  );

  pwm8_lvl u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .en_i      (cnt_en),
    .hit_per_i (hit_per),
    .hit_dty_i (hit_dty),
    .act_o     (act_q),
    .irq_o     (irq_q)
  );

  // stop takes effect on the pins in the same cycle
  assign pwm_o = (act_q & run_i) ^ inv_i;
  assign irq_o = irq_q & run_i;
endmodule

// File: rtl/pwm8_dual_cmp_chk.sv
module pwm8_dual_cmp_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         run_i,
  input logic         inv_i,
  input logic [W-1:0] period_i,
  input logic [W-1:0] duty_i,
  input logic [W-1:0] count_o,
  input logic         pwm_o,
  input logic         irq_o
);
  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(count_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && count_o != '0 && count_o != period_i)
      |=> count_o == W'($past(count_o) + 1'b1));

  p_wrap_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o == '0 && pwm_o == ~inv_i));

  p_duty_no_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && count_o != '0 && count_o == duty_i && count_o != period_i)
      |=> !irq_o);

  p_irq_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_idle_pins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (pwm_o == inv_i && !irq_o));

  p_stop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_o == '0);
endmodule

bind pwm8_dual_cmp pwm8_dual_cmp_chk #(.W(W)) u_chk (.*);

// File: tb/tb_pwm8_dual_cmp.sv
`timescale 1ns/1ps
module tb_pwm8_dual_cmp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, inv = 1'b0;
  logic [7:0] per = 8'd5, dty = 8'd2;
  logic [7:0] count;
  logic pwm, irq;
  int total = 0, bad = 0;

  // reference model state
  int m_cnt = 0;
  bit m_act = 0, m_irq = 0, m_arm = 1, prev_irq = 0;

  always #2 clk = ~clk;

  pwm8_dual_cmp dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run), .inv_i(inv),
    .period_i(per), .duty_i(dty), .count_o(count), .pwm_o(pwm), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !run) begin
      m_cnt = 0; m_act = 0; m_irq = 0; m_arm = 1;
    end else begin
      m_irq = 0;
      if (tick) begin
        if (m_arm) m_arm = 0;
        else if (m_cnt == int'(per)) begin
          m_cnt = 0; m_act = 1; m_irq = 1;
        end else begin
          if (m_cnt == int'(dty)) m_act = 0;
          m_cnt = (m_cnt + 1) % 256;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2 count", int'(count), m_cnt);
    chk("R5/R7 pwm", int'(pwm), int'((m_act & run) ^ inv));
    chk("R4 irq", int'(irq), int'(m_irq & run));
    if (prev_irq && irq) chk("R6 irq width", 1, 0);
    prev_irq = irq;
  endtask

  task automatic cyc(input bit t);
    tick = t;
    @(posedge clk); #1;
    cmp_model();
  endtask

  task automatic run_for(input int n, input int gap);
    for (int i = 0; i < n; i++) cyc((gap == 0) || (i % (gap + 1) == 0));
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int irqs;
    #9; rst_n = 1'b1;
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 pwm", int'(pwm), 0);
    chk("R1 irq", int'(irq), 0);
    inv = 1'b1; #1;
    chk("R1 pwm inv", int'(pwm), 1);
    inv = 1'b0;

    // R3: masked first tick
    run = 1'b1;
    cyc(1); chk("R3 masked", int'(count), 0);
    cyc(0); chk("R3 hold", int'(count), 0);
    cyc(1); chk("R3 first count", int'(count), 1);
    // count 1 -> 5, then wrap: R4
    run_for(4, 0); chk("R4 at period", int'(count), 5);
    cyc(1);
    chk("R4 wrap", int'(count), 0);
    chk("R4 irq", int'(irq), 1);
    chk("R7 active high", int'(pwm), 1);
    cyc(0); chk("R6 irq drops", int'(irq), 0);
    // R5: duty match 2 -> inactive after tick at count 2
    cyc(1); cyc(1); cyc(1);
    chk("R5 count past duty", int'(count), 3);
    chk("R5 inactive", int'(pwm), 0);
    chk("R5 no irq", int'(irq), 0);

    // sparse ticks, count irq pulses over several periods
    irqs = 0;
    for (int i = 0; i < 120; i++) begin
      cyc(i % 3 == 0);
      if (irq) irqs++;
    end
    chk("R6 pulses", irqs > 0 ? 1 : 0, 1);

    // R7 inverted polarity
    inv = 1'b1;
    run_for(60, 1);

    // R8 stop while active
    while (!(m_act && run)) cyc(1);
    run = 1'b0; #1;
    chk("R8 pwm inactive now", int'(pwm), 1);
    chk("R8 irq low now", int'(irq), 0);
    cyc(1); chk("R8 count cleared", int'(count), 0);
    run = 1'b1;
    cyc(1); chk("R8 remask", int'(count), 0);
    cyc(1); chk("R8 counting again", int'(count), 1);

    // corner: duty 0, period FF
    run = 1'b0; inv = 1'b0; cyc(0);
    dty = 8'd0; per = 8'hFF; run = 1'b1;
    run_for(600, 0);
    // corner: duty FE period FF with gaps
    run = 1'b0; cyc(0);
    dty = 8'hFE; run = 1'b1;
    run_for(900, 2);
    // short period 1, duty 0
    run = 1'b0; cyc(0);
    per = 8'd1; dty = 8'd0; run = 1'b1;
    run_for(40, 0);
    // stop during irq cycle
    while (!irq) cyc(1);
    run = 1'b0; #1;
    chk("R8 irq gated", int'(irq), 0);
    cyc(0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule